// File: doc/BRIEF.md
# CAN Transmit Dominant Timeout Guard

This block sits between the transmit output of a CAN protocol controller and the driver-enable pin of a line transceiver. The transmit line is active low: 0 is the dominant level and 1 is the recessive level. A local controller fault can leave that line stuck dominant and block every other node on the bus. The guard measures how long the line stays dominant. If it stays dominant past a set number of clock cycles, the guard switches the driver off.

The timer starts only on a recessive-to-dominant transition. A dominant-to-recessive transition stops it, and the driver comes back on. While the driver is off, the gated transmit output is held recessive. A sticky fault flag records each trip until software clears it with a pulse. The default limit equals seventeen bit times at 40 kbit/s, so legal frames never trip the guard at 40 kbit/s or any faster rate.

Top module: `can_dom_guard`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `drv_en` is 1, `fault` is 0 and the timer is idle.
- R2: Take a run of dominant samples (0) of `txd_in` on rising clock edges that follows a recessive sample. `drv_en` goes to 0 right after the edge that takes the (TIMEOUT_CYC+2)-th consecutive dominant sample. One sample fewer leaves `drv_en` at 1. The two extra edges are the synchronizer and the edge detector.
- R3: While `drv_en` is 1, `txd_out` equals `txd_in` with no clock delay. While `drv_en` is 0, `txd_out` is 1 whatever `txd_in` does.
- R4: Once tripped, the timer saturates at TIMEOUT_CYC and does not wrap. `drv_en` stays 0 for as long as `txd_in` stays 0.
- R5: A recessive sample of `txd_in` re-enables the driver after the third rising edge counted from that sample. The timer restarts from zero on the next dominant transition, so dominant runs separated by one recessive sample never add up.
- R6: `fault` becomes 1 on the edge after `drv_en` falls. It stays 1 after the driver is re-enabled, until it is cleared.
- R7: When `fault_clr` is sampled as 1 at an edge where the guard is not tripped, `fault` is 0 after that edge. When the guard is tripped, `fault_clr` has no effect.
- R8: If `txd_in` is already 0 when reset is released, the timer does not start. `drv_en` stays 1 until a recessive sample is followed by a new dominant run.
- R9: The default TIMEOUT_CYC equals 17 × CLK_HZ / MIN_BPS (42500 cycles at 100 MHz and 40 kbit/s). A limit of zero is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txd_in | input | 1 | Transmit data from the protocol controller, 0 = dominant |
| fault_clr | input | 1 | Single-cycle pulse that clears the sticky fault flag |
| drv_en | output | 1 | Transceiver driver enable, 0 while tripped |
| txd_out | output | 1 | Gated transmit data, held at 1 while tripped |
| fault | output | 1 | Sticky flag: at least one timeout has occurred |

## Verification
The hardest cases to reach are the exact trip boundary and the timer restart after a very short recessive gap. Both depend on the sample-to-enable latency through the synchronizer and the edge detector. Directed sequences hold the line dominant for exactly TIMEOUT_CYC+1 and TIMEOUT_CYC+2 samples. They also split two sub-limit runs with a single recessive cycle, and release reset with the line already dominant. Seeded random runs of dominant and recessive phases, with clear pulses inside both, are compared every cycle against a bench model that counts delayed samples. A second instance with default parameters is held dominant for the full default window.

// File: rtl/can_guard_pkg.sv
// Package: shared types and sizing helpers for the dominant timeout guard.
// Assumes: integer clock and bit-rate values, with clk_hz >= min_bps.
package can_guard_pkg;

    // Timer state: idle, counting a dominant run, or tripped (driver off).
    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_TRIP = 2'd2
    } tmr_state_e;

    // Clock cycles that span a given number of bit times at the slowest bit rate.
    function automatic int unsigned timeout_cycles(input int unsigned clk_hz,
                                                   input int unsigned min_bps,
                                                   input int unsigned bits);
        return (clk_hz / min_bps) * bits;
    endfunction

endpackage

// File: rtl/can_guard_sync.sv
// Module: multi-stage synchronizer for the asynchronous transmit input.
// Assumes: STAGES >= 2. All flops reset to the dominant level (0), so an
// input already held dominant at reset release produces no transition.
module can_guard_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] shf_q;

    if (STAGES < 2) begin : g_bad_stages
        $error("can_guard_sync: STAGES must be at least 2");
    end

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin : p_shift
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= {shf_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = shf_q[STAGES-1];

endmodule

// File: rtl/can_guard_edge.sv
// Module: transition detector on the synchronized transmit level.
// Assumes: the input is already synchronous to clk. The history flop resets
// to dominant (0), matching the synchronizer reset value.
module can_guard_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o,
    output logic rise_o
);

    logic prev_q;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin : p_hist
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign fall_o = prev_q & ~lvl_i;
    assign rise_o = ~prev_q & lvl_i;

endmodule

// File: rtl/can_guard_timer.sv
// Module: dominant-run timer. It starts on a fall, counts up to LIMIT and
// saturates there in the tripped state. A rise returns it to idle.
// Assumes: LIMIT >= 1. A fall and a rise never occur in the same cycle.
module can_guard_timer
    import can_guard_pkg::*;
#(
    parameter int LIMIT = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             rise_i,
    output logic             trip_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(LIMIT - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    tmr_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;

    if (LIMIT < 1) begin : g_bad_limit
        $error("can_guard_timer: LIMIT must be nonzero");
    end

    // Advance the dominant-run counter and the trip state.
    always_ff @(posedge clk) begin : p_timer
        if (!rst_n) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else if (rise_i) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                TMR_IDLE: begin
                    if (fall_i) begin
                        cnt_q <= ONE;
                        st_q  <= (LIMIT == 1) ? TMR_TRIP : TMR_RUN;
                    end
                end
                TMR_RUN: begin
                    cnt_q <= cnt_q + ONE;
                    if (cnt_q == LIM_M1) begin
                        st_q <= TMR_TRIP;
                    end
                end
                TMR_TRIP: begin
                    cnt_q <= cnt_q;
                end
                default: begin
                    st_q  <= TMR_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign trip_o = (st_q == TMR_TRIP);
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/can_guard_fault.sv
// Module: sticky fault flag. A trip sets it. A clear pulse resets it only
// while the guard is not tripped.
// Assumes: clr_i is a synchronous pulse.
module can_guard_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic clr_i,
    output logic fault_o
);

    logic flag_q;

    // Set on trip, clear on request outside a trip, hold otherwise.
    always_ff @(posedge clk) begin : p_flag
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (trip_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign fault_o = flag_q;

endmodule

// File: rtl/can_dom_guard.sv
// Module: CAN transmit dominant timeout guard (top).
// It watches the controller's transmit line. A dominant run that lasts longer
// than TIMEOUT_CYC clock cycles turns the transceiver driver off and forces
// the gated output recessive. The next recessive level re-enables the driver.
// Assumes: txd_in may be asynchronous to clk. 0 is dominant.
module can_dom_guard
    import can_guard_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int MIN_BPS     = 40_000,
    parameter int DOM_BITS    = 17,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = int'(timeout_cycles(CLK_HZ, MIN_BPS, DOM_BITS))
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_in,
    input  logic fault_clr,
    output logic drv_en,
    output logic txd_out,
    output logic fault
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic             txd_sync;
    logic             edge_fall;
    logic             edge_rise;
    logic             tmr_trip;
    logic [CNT_W-1:0] tmr_cnt;

    can_guard_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (txd_in),
        .q_o   (txd_sync)
    );

    can_guard_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (txd_sync),
        .fall_o (edge_fall),
        .rise_o (edge_rise)
    );

    can_guard_timer #(
        .LIMIT (TIMEOUT_CYC),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_i (edge_fall),
        .rise_i (edge_rise),
        .trip_o (tmr_trip),
        .cnt_o  (tmr_cnt)
    );

    can_guard_fault u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip_i  (tmr_trip),
        .clr_i   (fault_clr),
        .fault_o (fault)
    );

    // Driver enable and the gated transmit path (no added latency).
    assign drv_en  = ~tmr_trip;
    assign txd_out = drv_en ? txd_in : 1'b1;

endmodule

// File: rtl/can_dom_guard_chk.sv
// Module: assertion checker for can_dom_guard. It is attached through bind
// and observes the ports together with the timer count and the rise strobe.
// Assumes: the same clock and synchronous active-low reset as the guard.
module can_dom_guard_chk #(
    parameter int TIMEOUT_CYC = 4,
    parameter int CNT_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fault_clr,
    input logic             drv_en,
    input logic             txd_out,
    input logic             fault,
    input logic             rise,
    input logic [CNT_W-1:0] cnt
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (drv_en && !fault));

    assert_trip_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> (cnt == CNT_W'(TIMEOUT_CYC)));

    assert_recessive_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> txd_out);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(TIMEOUT_CYC));

    assert_stay_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_en && !rise) |=> !drv_en);

    assert_reenable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> drv_en);

    assert_fault_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |=> fault);

    assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);

    assert_clr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> fault);

    assert_clr_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_clr && drv_en) |=> !fault);

endmodule

bind can_dom_guard can_dom_guard_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_clr (fault_clr),
    .drv_en    (drv_en),
    .txd_out   (txd_out),
    .fault     (fault),
    .rise      (edge_rise),
    .cnt       (tmr_cnt)
);

// File: tb/test_can_dom_guard.sv
`timescale 1ns/1ps
module test_can_dom_guard;

    localparam int LIM  = 24;
    localparam int DFLT = 17 * (100_000_000 / 40_000);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd_in = 1'b0;
    logic fault_clr = 1'b0;
    logic drv_en, txd_out, fault;
    logic txd2 = 1'b1;
    logic clr2 = 1'b0;
    logic drv_en2, txd_out2, fault2;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  auto_on = 1'b0;

    always #5 clk = ~clk;

    can_dom_guard #(.TIMEOUT_CYC(LIM)) i_can_dom_guard (
        .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .fault_clr(fault_clr),
        .drv_en(drv_en), .txd_out(txd_out), .fault(fault)
    );

    can_dom_guard i_can_dom_guard_dflt (
        .clk(clk), .rst_n(rst_n), .txd_in(txd2), .fault_clr(clr2),
        .drv_en(drv_en2), .txd_out(txd_out2), .fault(fault2)
    );

    // Bench model: delayed samples, a dominant-run length and an arm flag.
    logic h1, h2, darm, m_fault;
    int   dlow;

    function automatic bit exp_off(input bit armed, input int low);
        return armed && (low >= LIM);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 <= 1'b0; h2 <= 1'b0; darm <= 1'b0; dlow <= 0; m_fault <= 1'b0;
        end else begin
            m_fault <= exp_off(darm, dlow) ? 1'b1 : (fault_clr ? 1'b0 : m_fault);
            h1 <= txd_in;
            h2 <= h1;
            if (h2) begin
                darm <= 1'b1;
                dlow <= 0;
            end else if (dlow < LIM) begin
                dlow <= dlow + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, late in the low clock phase.
    always @(negedge clk) begin
        if (auto_on && rst_n) begin
            #3;
            check(drv_en == !exp_off(darm, dlow), "R2 R4 R5", "drv_en",
                  int'(drv_en), int'(!exp_off(darm, dlow)));
            check(txd_out == (exp_off(darm, dlow) ? 1'b1 : txd_in), "R3", "txd_out",
                  int'(txd_out), int'(exp_off(darm, dlow) ? 1'b1 : txd_in));
            check(fault == m_fault, "R6 R7", "fault", int'(fault), int'(m_fault));
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(1_900_000);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung run, expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: state during reset, with the line already dominant
        repeat (4) @(posedge clk);
        #1;
        check(drv_en == 1'b1, "R1", "drv_en in reset", int'(drv_en), 1);
        check(fault == 1'b0, "R1", "fault in reset", int'(fault), 0);
        check(txd_out == 1'b0, "R1", "txd_out passes in reset", int'(txd_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        auto_on = 1'b1;

        // R8: dominant from before reset release must not trip
        repeat (3 * LIM) @(posedge clk);
        #1;
        check(drv_en == 1'b1, "R8", "drv_en held dominant from reset", int'(drv_en), 1);

        // R2: exact trip boundary
        @(negedge clk); txd_in = 1'b1;
        repeat (6) @(negedge clk);
        txd_in = 1'b0;
        repeat (LIM + 1) @(posedge clk);
        #1;
        check(drv_en == 1'b1, "R2", "drv_en one sample short", int'(drv_en), 1);
        @(posedge clk); #1;
        check(drv_en == 1'b0, "R2", "drv_en at limit", int'(drv_en), 0);
        check(txd_out == 1'b1, "R3", "txd_out forced recessive", int'(txd_out), 1);

        // R4: long hold past any counter wrap
        repeat (2 * LIM) @(posedge clk);
        #1;
        check(drv_en == 1'b0, "R4", "drv_en stays off", int'(drv_en), 0);
        check(fault == 1'b1, "R6", "fault set", int'(fault), 1);

        // R7: clear while tripped is ignored
        @(negedge clk); fault_clr = 1'b1;
        @(negedge clk); fault_clr = 1'b0;
        @(posedge clk); #1;
        check(fault == 1'b1, "R7", "clear ignored while tripped", int'(fault), 1);

        // R5: re-enable latency
        @(negedge clk); txd_in = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check(drv_en == 1'b0, "R5", "drv_en before latency", int'(drv_en), 0);
        @(posedge clk); #1;
        check(drv_en == 1'b1, "R5", "drv_en re-enabled", int'(drv_en), 1);
        check(fault == 1'b1, "R6", "fault sticky after re-enable", int'(fault), 1);

        // R7: clear outside a trip
        @(negedge clk); fault_clr = 1'b1;
        @(negedge clk); fault_clr = 1'b0;
        #1;
        check(fault == 1'b0, "R7", "fault cleared", int'(fault), 0);

        // R5: two sub-limit runs split by a single recessive cycle
        repeat (3) @(negedge clk);
        txd_in = 1'b0;
        repeat (LIM) @(negedge clk);
        txd_in = 1'b1;
        @(negedge clk); txd_in = 1'b0;
        repeat (LIM) @(negedge clk);
        txd_in = 1'b1;
        #1;
        check(drv_en == 1'b1, "R5", "runs do not accumulate", int'(drv_en), 1);

        // Random runs with clear pulses in both phases
        for (int seg = 0; seg < 300; seg++) begin
            int hi_len;
            int lo_len;
            hi_len = 1 + int'($urandom % 5);
            lo_len = ($urandom % 4 == 0) ? (LIM + 2 + int'($urandom % LIM))
                                          : (1 + int'($urandom % (LIM + 3)));
            for (int k = 0; k < hi_len; k++) begin
                @(negedge clk);
                txd_in = 1'b1;
                fault_clr = ($urandom % 4 == 0);
            end
            for (int k = 0; k < lo_len; k++) begin
                @(negedge clk);
                txd_in = 1'b0;
                fault_clr = ($urandom % 8 == 0);
            end
        end
        @(negedge clk);
        txd_in = 1'b1;
        fault_clr = 1'b0;
        repeat (4) @(negedge clk);
        auto_on = 1'b0;

        // R9: default limit on the default-parameter instance
        @(negedge clk); txd2 = 1'b0;
        repeat (DFLT + 1) @(posedge clk);
        #1;
        check(drv_en2 == 1'b1, "R9", "default one sample short", int'(drv_en2), 1);
        @(posedge clk); #1;
        check(drv_en2 == 1'b0, "R9", "default trips at 42500", int'(drv_en2), 0);
        check(txd_out2 == 1'b1, "R9", "default gated output", int'(txd_out2), 1);

        summary();
        $finish;
    end

endmodule